// File: doc/BRIEF.md
# Transmit Descriptor Status Collector

This block sits beside a transmit engine and watches the 16-bit status words of buffer descriptors as they are retired. Each retired word is decoded into six error events: deferred frame, heartbeat error, late collision, retry limit exceeded, transmit underrun and carrier sense lost. Each event has its own saturating counter. A 4-bit retry-count field in the word is added to a saturating running retry total.

Descriptors are handed over in batches. A word whose hardware-ownership bit is still set ends the scan for the rest of the batch, so neither that word nor any later word in the same batch is counted. When the batch closes, a one-cycle restart request is raised if any retired word in the batch carried one of the fatal errors (late collision, retry limit or underrun). The other three errors never cause a restart. A synchronous clear input zeroes all counters.

Top module: `txstat_collector`

## Requirements
- R1: After reset all seven counters read zero and `restart_req` is low.
- R2: A retired word (valid, ownership bit 15 clear, scan not stopped) adds one to each event counter whose flag is set: bit 9 deferred (`cnt_defer`), bit 8 heartbeat (`cnt_hbeat`), bit 7 late collision (`cnt_latecol`), bit 6 retry limit (`cnt_rtylim`), bit 1 underrun (`cnt_underrun`), bit 0 carrier lost (`cnt_crsloss`). The new values are visible in the cycle after the strobe.
- R3: A retired word adds its bits [5:2], read as an unsigned retry count, to `retry_total`.
- R4: A valid word with bit 15 set is not counted and stops the scan: every later valid word is ignored until `batch_end` has been seen.
- R5: `restart_req` is high for exactly the one cycle after a cycle with `batch_end` high, if a word retired in that batch (including one retired in the `batch_end` cycle itself) had bit 7, 6 or 1 set. Otherwise it stays low.
- R6: Words carrying only bits 9, 8 or 0 never raise `restart_req`.
- R7: Every counter saturates at its all-ones value. The retry total clamps there instead of wrapping.
- R8: `clr` zeroes every counter on the next edge and takes priority over a same-cycle increment. It does not affect the scan-stop or restart tracking.
- R9: A single word with several flags increments each of the matching counters in the same cycle.
- R10: `batch_end` clears the stopped scan and the pending restart, so the next batch starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of all counters |
| desc_valid | input | 1 | Status word strobe |
| desc_status | input | 16 | Descriptor status word |
| batch_end | input | 1 | Closes the current retirement batch |
| cnt_defer | output | CNT_W | Deferred frame count |
| cnt_hbeat | output | CNT_W | Heartbeat error count |
| cnt_latecol | output | CNT_W | Late collision count |
| cnt_rtylim | output | CNT_W | Retry limit exceeded count |
| cnt_underrun | output | CNT_W | Underrun count |
| cnt_crsloss | output | CNT_W | Carrier sense lost count |
| retry_total | output | CNT_W | Accumulated retry count |
| restart_req | output | 1 | One-cycle transmitter restart request |

## Verification
Each counter is a single register stage, so a word strobed in a cycle shows its effect in the cycle after, and `restart_req` likewise follows `batch_end` by one edge. The bench drives every input on the falling edge, lets one rising edge pass, and compares all outputs at the next falling edge against a model that it advances once per edge. With this single-step pacing, a mistimed increment or a pulse that arrives late or lasts two cycles shows up as a mismatch.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
   localparam int NUM_EV    = 6;
   localparam int OWN_BIT   = 15;
   localparam int RETRY_LSB = 2;
   localparam int RETRY_W   = 4;

   typedef enum logic [2:0] {
      EV_DEFER   = 3'd0,
      EV_HBEAT   = 3'd1,
      EV_LATECOL = 3'd2,
      EV_RTYLIM  = 3'd3,
      EV_UNDERRN = 3'd4,
      EV_CRSLOSS = 3'd5
   } ev_e;

   // bit position of each event flag in the status word, by ev_e index
   function automatic int ev_pos(input int idx);
      case (idx)
         0:       return 9;
         1:       return 8;
         2:       return 7;
         3:       return 6;
         4:       return 1;
         default: return 0;
      endcase
   endfunction

   // events that demand a transmitter restart
   function automatic bit ev_fatal(input int idx);
      return (idx == int'(EV_LATECOL)) || (idx == int'(EV_RTYLIM)) ||
             (idx == int'(EV_UNDERRN));
   endfunction
endpackage

// File: rtl/txstat_sat_counter.sv
module txstat_sat_counter #(
   parameter int CNT_W = 32,
   parameter int INC_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc_en,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] MAX_VAL = '1;

   logic [CNT_W:0] sum;

   if (INC_W > CNT_W) begin : g_bad_width
      $error("txstat_sat_counter: INC_W must not exceed CNT_W");
   end

   always_comb begin
      sum = {1'b0, count} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (inc_en) begin
         count <= sum[CNT_W] ? MAX_VAL : sum[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/txstat_scan.sv
module txstat_scan
   import txstat_pkg::*;
#(
   parameter int STAT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               desc_valid,
   input  logic [STAT_W-1:0]  desc_status,
   input  logic               batch_end,
   output logic               retire,
   output logic [NUM_EV-1:0]  ev_hit,
   output logic [RETRY_W-1:0] retry_cnt,
   output logic               fatal_hit
);
   logic stopped;
   logic fatal_mask [NUM_EV];

   always_comb begin
      retire    = desc_valid && !desc_status[OWN_BIT] && !stopped;
      retry_cnt = desc_status[RETRY_LSB +: RETRY_W];
   end

   for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
      assign ev_hit[i]     = retire && desc_status[ev_pos(i)];
      assign fatal_mask[i] = ev_fatal(i) ? ev_hit[i] : 1'b0;
   end

   always_comb begin
      fatal_hit = 1'b0;
      for (int i = 0; i < NUM_EV; i++) begin
         fatal_hit = fatal_hit | fatal_mask[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stopped <= 1'b0;
      end else if (batch_end) begin
         stopped <= 1'b0;
      end else if (desc_valid && desc_status[OWN_BIT]) begin
         stopped <= 1'b1;
      end
   end
endmodule

// File: rtl/txstat_restart.sv
module txstat_restart (
   input  logic clk,
   input  logic rst_n,
   input  logic fatal_hit,
   input  logic batch_end,
   output logic restart_req
);
   logic pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending     <= 1'b0;
         restart_req <= 1'b0;
      end else begin
         restart_req <= batch_end && (pending || fatal_hit);
         pending     <= batch_end ? 1'b0 : (pending || fatal_hit);
      end
   end
endmodule

// File: rtl/txstat_collector.sv
module txstat_collector
   import txstat_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int STAT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              desc_valid,
   input  logic [STAT_W-1:0] desc_status,
   input  logic              batch_end,
   output logic [CNT_W-1:0]  cnt_defer,
   output logic [CNT_W-1:0]  cnt_hbeat,
   output logic [CNT_W-1:0]  cnt_latecol,
   output logic [CNT_W-1:0]  cnt_rtylim,
   output logic [CNT_W-1:0]  cnt_underrun,
   output logic [CNT_W-1:0]  cnt_crsloss,
   output logic [CNT_W-1:0]  retry_total,
   output logic              restart_req
);
   if (STAT_W != 16) begin : g_bad_stat
      $error("txstat_collector: status word must be 16 bits");
   end
   if (CNT_W <= RETRY_W) begin : g_bad_cnt
      $error("txstat_collector: CNT_W must exceed the retry field width");
   end

   logic               retire;
   logic [NUM_EV-1:0]  ev_hit;
   logic [RETRY_W-1:0] retry_cnt;
   logic               fatal_hit;
   logic [CNT_W-1:0]   ev_count [NUM_EV];

   txstat_scan #(.STAT_W(STAT_W)) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .desc_valid (desc_valid),
      .desc_status(desc_status),
      .batch_end  (batch_end),
      .retire     (retire),
      .ev_hit     (ev_hit),
      .retry_cnt  (retry_cnt),
      .fatal_hit  (fatal_hit)
   );

   for (genvar i = 0; i < NUM_EV; i++) begin : g_evcnt
      txstat_sat_counter #(.CNT_W(CNT_W), .INC_W(1)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .inc_en(ev_hit[i]),
         .inc   (1'b1),
         .count (ev_count[i])
      );
   end

   txstat_sat_counter #(.CNT_W(CNT_W), .INC_W(RETRY_W)) u_retry (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc_en(retire),
      .inc   (retry_cnt),
      .count (retry_total)
   );

   txstat_restart u_restart (
      .clk        (clk),
      .rst_n      (rst_n),
      .fatal_hit  (fatal_hit),
      .batch_end  (batch_end),
      .restart_req(restart_req)
   );

   assign cnt_defer    = ev_count[EV_DEFER];
   assign cnt_hbeat    = ev_count[EV_HBEAT];
   assign cnt_latecol  = ev_count[EV_LATECOL];
   assign cnt_rtylim   = ev_count[EV_RTYLIM];
   assign cnt_underrun = ev_count[EV_UNDERRN];
   assign cnt_crsloss  = ev_count[EV_CRSLOSS];
endmodule

// File: rtl/txstat_collector_chk.sv
module txstat_collector_chk #(
   parameter int CNT_W  = 32,
   parameter int STAT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              desc_valid,
   input logic [STAT_W-1:0] desc_status,
   input logic              batch_end,
   input logic [CNT_W-1:0]  cnt_defer,
   input logic [CNT_W-1:0]  cnt_hbeat,
   input logic [CNT_W-1:0]  cnt_latecol,
   input logic [CNT_W-1:0]  cnt_rtylim,
   input logic [CNT_W-1:0]  cnt_underrun,
   input logic [CNT_W-1:0]  cnt_crsloss,
   input logic [CNT_W-1:0]  retry_total,
   input logic              restart_req
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   // R4: an owned word leaves every counter untouched
   p_owned_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && desc_status[15] && !clr) |=>
         ($stable(cnt_defer) && $stable(cnt_hbeat) && $stable(cnt_latecol) &&
          $stable(cnt_rtylim) && $stable(cnt_underrun) && $stable(cnt_crsloss) &&
          $stable(retry_total)));

   // R2: without a strobe nothing counts
   p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!desc_valid && !clr) |=> ($stable(cnt_latecol) && $stable(retry_total)));

   // R8: clear empties every counter
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_defer == '0 && cnt_hbeat == '0 && cnt_latecol == '0 &&
               cnt_rtylim == '0 && cnt_underrun == '0 && cnt_crsloss == '0 &&
               retry_total == '0));

   // R5: a restart request only ever follows a batch end
   p_restart_after_batch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |-> $past(batch_end));

   // R7: a saturated counter holds its value
   p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_total == MAXV && !clr) |=> (retry_total == MAXV));

   // R3: one word adds at most fifteen retries
   p_retry_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((retry_total >= $past(retry_total)) &&
                (retry_total - $past(retry_total) <= CNT_W'(15))));

   // R2: an event counter grows by at most one per cycle
   p_ev_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((cnt_underrun == $past(cnt_underrun)) ||
                (cnt_underrun == $past(cnt_underrun) + CNT_W'(1))));
endmodule

bind txstat_collector txstat_collector_chk #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_chk (.*);

// File: tb/txstat_collector_tb_top.sv
`timescale 1ns/1ps
module txstat_collector_tb_top;
   localparam int CW = 8;
   localparam int MAXV = (1 << CW) - 1;
   localparam int NV = 13;
   // {valid, batch_end, expected restart after this cycle, status}
   localparam logic [18:0] VEC [NV] = '{
      {1'b1, 1'b0, 1'b0, 16'h0200},
      {1'b1, 1'b0, 1'b0, 16'h0100},
      {1'b1, 1'b1, 1'b0, 16'h0001},
      {1'b1, 1'b0, 1'b0, 16'h0080},
      {1'b1, 1'b1, 1'b1, 16'h0000},
      {1'b1, 1'b0, 1'b0, 16'h003C},
      {1'b1, 1'b0, 1'b0, 16'h0042},
      {1'b1, 1'b0, 1'b0, 16'h8080},
      {1'b1, 1'b1, 1'b1, 16'h0083},
      {1'b1, 1'b0, 1'b0, 16'h0014},
      {1'b0, 1'b1, 1'b0, 16'h0000},
      {1'b1, 1'b1, 1'b1, 16'h0002},
      {1'b1, 1'b1, 1'b1, 16'h03C3}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0, desc_valid = 1'b0, batch_end = 1'b0;
   logic [15:0] desc_status = '0;
   logic [CW-1:0] c_def, c_hb, c_lc, c_rl, c_un, c_cs, c_rt;
   logic restart_req;

   int checks = 0, failures = 0;
   int exp_c [7];
   bit m_stop = 0, m_pend = 0, m_rst = 0;

   always #4 clk = ~clk;

   txstat_collector #(.CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .desc_valid(desc_valid),
      .desc_status(desc_status), .batch_end(batch_end),
      .cnt_defer(c_def), .cnt_hbeat(c_hb), .cnt_latecol(c_lc),
      .cnt_rtylim(c_rl), .cnt_underrun(c_un), .cnt_crsloss(c_cs),
      .retry_total(c_rt), .restart_req(restart_req));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      chk(tag, "cnt_defer", int'(c_def), exp_c[0]);
      chk(tag, "cnt_hbeat", int'(c_hb), exp_c[1]);
      chk(tag, "cnt_latecol", int'(c_lc), exp_c[2]);
      chk(tag, "cnt_rtylim", int'(c_rl), exp_c[3]);
      chk(tag, "cnt_underrun", int'(c_un), exp_c[4]);
      chk(tag, "cnt_crsloss", int'(c_cs), exp_c[5]);
      chk(tag, "retry_total", int'(c_rt), exp_c[6]);
      chk(tag, "restart_req", int'(restart_req), int'(m_rst));
   endtask

   function automatic int sat(input int v);
      return (v > MAXV) ? MAXV : v;
   endfunction

   // model advanced once per rising edge, built from R2..R10
   task automatic model(input bit v, input logic [15:0] st, input bit be, input bit c);
      bit ret, fat;
      ret = v && !st[15] && !m_stop;
      fat = ret && (st[7] || st[6] || st[1]);
      if (c) begin
         for (int i = 0; i < 7; i++) exp_c[i] = 0;
      end else if (ret) begin
         exp_c[0] = sat(exp_c[0] + int'(st[9]));
         exp_c[1] = sat(exp_c[1] + int'(st[8]));
         exp_c[2] = sat(exp_c[2] + int'(st[7]));
         exp_c[3] = sat(exp_c[3] + int'(st[6]));
         exp_c[4] = sat(exp_c[4] + int'(st[1]));
         exp_c[5] = sat(exp_c[5] + int'(st[0]));
         exp_c[6] = sat(exp_c[6] + int'(st[5:2]));
      end
      m_rst  = be && (m_pend || fat);
      m_pend = be ? 1'b0 : (m_pend || fat);
      m_stop = be ? 1'b0 : ((v && st[15]) ? 1'b1 : m_stop);
   endtask

   task automatic step(input bit v, input logic [15:0] st, input bit be, input bit c);
      desc_valid  = v;
      desc_status = st;
      batch_end   = be;
      clr         = c;
      @(posedge clk);
      model(v, st, be, c);
      @(negedge clk);
      desc_valid = 0; batch_end = 0; clr = 0; desc_status = '0;
   endtask

   initial begin
      for (int i = 0; i < 7; i++) exp_c[i] = 0;
      repeat (3) @(negedge clk);
      chk_all("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1 after reset");

      // table walk: R2 R3 R4 R5 R6 R9 R10
      for (int k = 0; k < NV; k++) begin
         step(VEC[k][18], VEC[k][15:0], VEC[k][17], 1'b0);
         chk_all($sformatf("R2/R3/R4 vec%0d", k));
         chk($sformatf("R5 R6 R10 vec%0d", k), "table restart",
             int'(restart_req), int'(VEC[k][16]));
      end
      // R5: pulse lasts a single cycle
      step(1'b0, 16'h0, 1'b0, 1'b0);
      chk("R5 single cycle", "restart_req", int'(restart_req), 0);

      // R8: clear wins over same-cycle increment, keeps pending restart
      step(1'b1, 16'h0083, 1'b0, 1'b1);
      chk_all("R8 clear with strobe");
      chk("R8 clear priority", "cnt_latecol", int'(c_lc), 0);
      step(1'b0, 16'h0, 1'b1, 1'b0);
      chk("R8 pending survives clear", "restart_req", int'(restart_req), 1);

      // R7: retry total saturation
      for (int k = 0; k < 18; k++) step(1'b1, 16'h003C, 1'b0, 1'b0);
      chk("R7 retry clamp", "retry_total", int'(c_rt), MAXV);
      // R7: event counter saturation
      for (int k = 0; k < 260; k++) step(1'b1, 16'h0001, 1'b0, 1'b0);
      chk("R7 event clamp", "cnt_crsloss", int'(c_cs), MAXV);
      chk_all("R7 all");
      step(1'b0, 16'h0, 1'b1, 1'b0);
      chk_all("R6 carrier-only batch no restart");

      // R4: owned word then more words, counters frozen until batch end
      step(1'b1, 16'h8200, 1'b0, 1'b1);
      step(1'b1, 16'h0202, 1'b0, 1'b0);
      chk("R4 stopped scan", "cnt_defer", int'(c_def), 0);
      step(1'b0, 16'h0, 1'b1, 1'b0);
      chk("R4 no restart from ignored word", "restart_req", int'(restart_req), 0);
      step(1'b1, 16'h0202, 1'b0, 1'b0);
      chk_all("R10 scan resumes");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 150000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule